// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block divides a fast input clock by a programmable integer N = P·B + A. It is the feedback divider of an integer-N synthesizer: the divided pulse goes to a phase-frequency detector, so the locked oscillator runs at N times the comparison frequency. The step between output frequencies is therefore one comparison frequency.

N is not built from one plain modulo-N counter. A prescaler divides by P+1 or by P, and two counters run on the prescaler periods. The swallow counter holds A and the main counter holds B. Each output interval opens with the prescaler at P+1 while the swallow counter runs down. Once the swallow counter is empty, the prescaler divides by P until the main counter expires. That expiry reloads both counters and produces one output pulse.

A, B and the prescaler choice are written together as a single word, strobed by `cfg_load`. A stored word takes effect only at the next interval boundary, so an interval that has started is never changed. The counter widths are parameters: the defaults are a 6-bit A and an 11-bit B, and a 5-bit A with a 13-bit B is an equally valid setting. The prescaler is modelled as ordinary logic clocked by the input clock.

Top module: `dms_divider`

## Requirements
- R1: The distance between consecutive rising edges of `div_pulse` is exactly P·B + A input clocks, where P = 8·2^`cfg_psel` and A, B are the adopted settings.
- R2: `cfg_psel` selects the modulus pair: 0 gives 8/9, 1 gives 16/17, 2 gives 32/33 and 3 gives 64/65. The first A prescaler periods of each interval use P+1 and the remaining B−A periods use P.
- R3: With A = 0, every prescaler period uses P and the interval is P·B clocks.
- R4: With A = B, every prescaler period uses P+1 and the interval is (P+1)·B clocks.
- R5: `div_pulse` is high for exactly one input clock in each interval.
- R6: A valid word sampled with `cfg_load` high is adopted at the next interval boundary, which is the clock edge at which `div_pulse` rises. The interval in progress finishes with its old N.
- R7: `cfg_invalid` depends only on the word currently presented. It is high when `cfg_b` < 2 or `cfg_b` < `cfg_a`, and low otherwise.
- R8: A word presented with `cfg_load` high while `cfg_invalid` is high is discarded, and N stays unchanged.
- R9: While `rst_n` is low, `div_pulse` is low and the settings return to A = 0, B = 2, `cfg_psel` = 0, which gives N = 16. After the two-stage reset release, the first pulse is visible N + 2 clocks after `rst_n` rises.
- R10: When several valid words are loaded within one interval, the last one is adopted at the boundary.
- R11: A valid word sampled on the boundary edge itself is adopted for the interval that begins at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_load | input | 1 | Strobe that samples the presented word |
| cfg_a | input | A_W (6) | Swallow count A |
| cfg_b | input | B_W (11) | Main count B |
| cfg_psel | input | 2 | Prescaler modulus pair select |
| cfg_invalid | output | 1 | Presented word breaks B ≥ 2 or B ≥ A |
| div_pulse | output | 1 | One-clock divided output pulse |

## Verification
The hardest collision is a load strobe that arrives on the same edge that closes an interval. At that edge the word is captured, the counters reload and the pulse is produced, all at once. The bench provokes this by waiting exactly N−1 clocks after an observed pulse before it raises `cfg_load`. It then requires the pulse to appear on the next sample and the interval that follows to match the new word. A load issued just after a boundary is judged the opposite way: the interval already in progress must keep the old N.

// File: rtl/dms_pkg.sv
package dms_pkg;
  // log2 of the smallest prescaler modulus (select 0 -> 8/9)
  localparam int unsigned P_MIN_LOG2 = 3;
  localparam int unsigned PSEL_W     = 2;
  // wide enough for the largest modulus P+1 = 2^(P_MIN_LOG2 + 2^PSEL_W - 1) + 1
  localparam int unsigned PC_W       = P_MIN_LOG2 + (1 << PSEL_W);

  typedef enum logic [PSEL_W-1:0] {
    MOD_8_9   = 2'd0,
    MOD_16_17 = 2'd1,
    MOD_32_33 = 2'd2,
    MOD_64_65 = 2'd3
  } presc_sel_e;
endpackage

// File: rtl/dms_cfg_stage.sv
module dms_cfg_stage
  import dms_pkg::*;
#(
  parameter int unsigned A_W      = 6,
  parameter int unsigned B_W      = 11,
  parameter int unsigned RST_A    = 0,
  parameter int unsigned RST_B    = 2,
  parameter int unsigned RST_PSEL = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [A_W-1:0]    cfg_a,
  input  logic [B_W-1:0]    cfg_b,
  input  logic [PSEL_W-1:0] cfg_psel,
  input  logic              boundary,
  output logic              word_bad,
  output logic [A_W-1:0]    act_a,
  output logic [B_W-1:0]    act_b,
  output logic [PSEL_W-1:0] act_psel,
  output logic [A_W-1:0]    load_a,
  output logic [B_W-1:0]    load_b
);

  logic [B_W-1:0]    a_wide;
  logic              take;
  logic              pend_vld, pend_vld_nxt;
  logic [A_W-1:0]    pend_a, pend_a_nxt;
  logic [B_W-1:0]    pend_b, pend_b_nxt;
  logic [PSEL_W-1:0] pend_psel, pend_psel_nxt;
  logic [A_W-1:0]    act_a_nxt;
  logic [B_W-1:0]    act_b_nxt;
  logic [PSEL_W-1:0] act_psel_nxt;

  assign a_wide   = B_W'(cfg_a);
  assign word_bad = (cfg_b < B_W'(2)) || (cfg_b < a_wide);
  assign take     = cfg_load && !word_bad;

  // pending word: the last valid one wins; it is dropped once adopted
  always_comb begin
    pend_vld_nxt  = pend_vld;
    pend_a_nxt    = pend_a;
    pend_b_nxt    = pend_b;
    pend_psel_nxt = pend_psel;
    if (take) begin
      pend_a_nxt    = cfg_a;
      pend_b_nxt    = cfg_b;
      pend_psel_nxt = cfg_psel;
      pend_vld_nxt  = !boundary;
    end else if (boundary) begin
      pend_vld_nxt  = 1'b0;
    end
  end

  // active word changes only at a boundary; a word arriving on that edge bypasses the pending copy
  always_comb begin
    act_a_nxt    = act_a;
    act_b_nxt    = act_b;
    act_psel_nxt = act_psel;
    if (boundary) begin
      if (take) begin
        act_a_nxt    = cfg_a;
        act_b_nxt    = cfg_b;
        act_psel_nxt = cfg_psel;
      end else if (pend_vld) begin
        act_a_nxt    = pend_a;
        act_b_nxt    = pend_b;
        act_psel_nxt = pend_psel;
      end
    end
  end

  assign load_a = act_a_nxt;
  assign load_b = act_b_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_a    <= '0;
      pend_b    <= '0;
      pend_psel <= '0;
      act_a     <= A_W'(RST_A);
      act_b     <= B_W'(RST_B);
      act_psel  <= PSEL_W'(RST_PSEL);
    end else begin
      pend_vld  <= pend_vld_nxt;
      pend_a    <= pend_a_nxt;
      pend_b    <= pend_b_nxt;
      pend_psel <= pend_psel_nxt;
      act_a     <= act_a_nxt;
      act_b     <= act_b_nxt;
      act_psel  <= act_psel_nxt;
    end
  end

  // R8
  act_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_b >= B_W'(2)) && (act_b >= B_W'(act_a)));

  // R6
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> ($stable(act_a) && $stable(act_b) && $stable(act_psel)));

endmodule

// File: rtl/dms_prescaler.sv
module dms_prescaler
  import dms_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PSEL_W-1:0] psel,
  input  logic              swallow,
  output logic              period_end
);

  logic [PC_W-1:0] pc, pc_nxt;
  logic [PC_W-1:0] modulus;

  // P = 8 << psel; one extra count while the swallow counter is not empty
  assign modulus    = (PC_W'(1 << P_MIN_LOG2) << psel) + PC_W'(swallow);
  assign period_end = (pc == (modulus - PC_W'(1)));

  always_comb begin
    pc_nxt = pc + PC_W'(1);
    if (period_end) pc_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_nxt;
  end

  // R2
  pc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc < modulus);

endmodule

// File: rtl/dms_swallow_ctr.sv
module dms_swallow_ctr #(
  parameter int unsigned A_W   = 6,
  parameter int unsigned B_W   = 11,
  parameter int unsigned RST_A = 0,
  parameter int unsigned RST_B = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           period_end,
  input  logic [A_W-1:0] load_a,
  input  logic [B_W-1:0] load_b,
  output logic           swallow,
  output logic           terminal
);

  logic [A_W-1:0] a_cnt, a_nxt;
  logic [B_W-1:0] b_cnt, b_nxt;

  assign swallow  = (a_cnt != '0);
  assign terminal = period_end && (b_cnt == B_W'(1));

  always_comb begin
    a_nxt = a_cnt;
    b_nxt = b_cnt;
    if (period_end) begin
      if (terminal) begin
        a_nxt = load_a;
        b_nxt = load_b;
      end else begin
        b_nxt = b_cnt - B_W'(1);
        if (swallow) a_nxt = a_cnt - A_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_cnt <= A_W'(RST_A);
      b_cnt <= B_W'(RST_B);
    end else begin
      a_cnt <= a_nxt;
      b_cnt <= b_nxt;
    end
  end

  // R1
  a_le_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    B_W'(a_cnt) <= b_cnt);

  // R1
  b_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_cnt != '0);

endmodule

// File: rtl/dms_divider.sv
module dms_divider
  import dms_pkg::*;
#(
  parameter int unsigned A_W      = 6,
  parameter int unsigned B_W      = 11,
  parameter int unsigned RST_A    = 0,
  parameter int unsigned RST_B    = 2,
  parameter int unsigned RST_PSEL = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [A_W-1:0]    cfg_a,
  input  logic [B_W-1:0]    cfg_b,
  input  logic [PSEL_W-1:0] cfg_psel,
  output logic              cfg_invalid,
  output logic              div_pulse
);

  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic [A_W-1:0]    act_a;
  logic [B_W-1:0]    act_b;
  logic [PSEL_W-1:0] act_psel;
  logic [A_W-1:0]    load_a;
  logic [B_W-1:0]    load_b;
  logic              swallow;
  logic              period_end;
  logic              terminal;

  // asynchronous assertion, two-stage synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  dms_cfg_stage #(
    .A_W(A_W), .B_W(B_W), .RST_A(RST_A), .RST_B(RST_B), .RST_PSEL(RST_PSEL)
  ) i_cfg (
    .clk(clk), .rst_n(rst_int_n), .cfg_load(cfg_load), .cfg_a(cfg_a),
    .cfg_b(cfg_b), .cfg_psel(cfg_psel), .boundary(terminal),
    .word_bad(cfg_invalid), .act_a(act_a), .act_b(act_b), .act_psel(act_psel),
    .load_a(load_a), .load_b(load_b)
  );

  dms_prescaler i_presc (
    .clk(clk), .rst_n(rst_int_n), .psel(act_psel), .swallow(swallow),
    .period_end(period_end)
  );

  dms_swallow_ctr #(
    .A_W(A_W), .B_W(B_W), .RST_A(RST_A), .RST_B(RST_B)
  ) i_ctr (
    .clk(clk), .rst_n(rst_int_n), .period_end(period_end), .load_a(load_a),
    .load_b(load_b), .swallow(swallow), .terminal(terminal)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) div_pulse <= 1'b0;
    else            div_pulse <= terminal;
  end

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    div_pulse |=> !div_pulse);

endmodule

// File: tb/test_dms_divider.sv
module test_dms_divider;
  localparam int A_W = 6;
  localparam int B_W = 11;
  localparam int NV  = 8;
  localparam int VA [NV] = '{3, 0, 5, 2, 1, 63, 0, 7};
  localparam int VB [NV] = '{5, 4, 5, 3, 2, 63, 2, 9};
  localparam int VS [NV] = '{0, 1, 1, 2, 3, 0,  3, 0};

  logic           clk = 1'b0;
  logic           rst_n;
  logic           cfg_load;
  logic [A_W-1:0] cfg_a;
  logic [B_W-1:0] cfg_b;
  logic [1:0]     cfg_psel;
  logic           cfg_invalid;
  logic           div_pulse;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  dms_divider #(.A_W(A_W), .B_W(B_W)) i_dms_divider (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_a(cfg_a),
    .cfg_b(cfg_b), .cfg_psel(cfg_psel), .cfg_invalid(cfg_invalid),
    .div_pulse(div_pulse)
  );

  function automatic int exp_n(input int a, input int b, input int s);
    return (8 << s) * b + a;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_word(input int a, input int b, input int s);
    cfg_a = A_W'(a); cfg_b = B_W'(b); cfg_psel = 2'(s); cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // from a negedge: wait for a pulse, then count clocks to the next one
  task automatic measure(output int n);
    int guard;
    guard = 0;
    while (div_pulse !== 1'b1 && guard < 20000) begin @(negedge clk); guard++; end
    n = 0;
    do begin @(negedge clk); n++; end while (div_pulse !== 1'b1 && n < 20000);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    rst_n = 1'b0; cfg_load = 1'b0; cfg_a = '0; cfg_b = B_W'(2); cfg_psel = '0;
    repeat (3) @(negedge clk);
    chk(div_pulse == 1'b0, "R9 reset pulse", int'(div_pulse), 0);
    rst_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (div_pulse !== 1'b1 && n < 1000);
    chk(n == 18, "R9 first pulse", n, 18);
    measure(n);
    chk(n == 16, "R9 default N", n, 16);

    // vector table: R1 general, R3 for A=0, R4 for A=B
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      load_word(VA[i], VB[i], VS[i]);
      measure(n);
      chk(n == exp_n(VA[i], VB[i], VS[i]),
          (VA[i] == 0) ? "R3 A=0" : ((VA[i] == VB[i]) ? "R4 A=B" : "R1 R2 interval"),
          n, exp_n(VA[i], VB[i], VS[i]));
    end

    // R5: single-clock pulse
    measure(n);
    @(negedge clk);
    chk(div_pulse == 1'b0, "R5 width", int'(div_pulse), 0);

    // R7: flag on presented word
    cfg_a = 6'd0; cfg_b = 11'd1; #1;
    chk(cfg_invalid == 1'b1, "R7 B<2", int'(cfg_invalid), 1);
    cfg_a = 6'd4; cfg_b = 11'd3; #1;
    chk(cfg_invalid == 1'b1, "R7 B<A", int'(cfg_invalid), 1);
    cfg_a = 6'd4; cfg_b = 11'd4; #1;
    chk(cfg_invalid == 1'b0, "R7 B=A", int'(cfg_invalid), 0);
    cfg_a = 6'd0; cfg_b = 11'd2; #1;
    chk(cfg_invalid == 1'b0, "R7 B=2", int'(cfg_invalid), 0);

    // R8: invalid word discarded, N stays 79
    @(negedge clk);
    load_word(5, 3, 1);
    measure(n);
    chk(n == 79, "R8 invalid ignored", n, 79);

    // R6: load right after a boundary; running interval keeps old N
    measure(n);
    load_word(0, 3, 0);
    n = 1;
    while (div_pulse !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
    chk(n == 79, "R6 old N kept", n, 79);
    measure(n);
    chk(n == 24, "R6 new N adopted", n, 24);

    // R10: two loads in one interval, last wins
    load_word(1, 2, 1);
    load_word(2, 4, 0);
    measure(n);
    chk(n == 34, "R10 last word", n, 34);

    // R11: load sampled on the boundary edge itself
    repeat (33) @(negedge clk);
    load_word(3, 4, 1);
    chk(div_pulse == 1'b1, "R11 boundary pulse", int'(div_pulse), 1);
    measure(n);
    chk(n == 67, "R11 same-edge adopt", n, 67);

    // R9: reset in mid-run restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(div_pulse == 1'b0, "R9 reset mid-run", int'(div_pulse), 0);
    rst_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (div_pulse !== 1'b1 && n < 1000);
    chk(n == 18, "R9 first pulse again", n, 18);
    measure(n);
    chk(n == 16, "R9 default N again", n, 16);

    finish_run();
  end
endmodule